// File: doc/BRIEF.md
# Switching-Activity Redundancy Governor

This block watches the 16-bit words produced by a compute unit and uses their switching activity as a stand-in for power draw. For each accepted word it counts how many bit positions differ from the previous accepted word. It keeps the last eight of these counts in a sliding window and derives an integer average from them. The average puts the load into one of three regimes. Heavy activity runs the original unit alone. Moderate activity adds one redundant replica. Light activity adds a second replica so that outputs can be voted.

The governor moves the replica population towards the level the current regime calls for, one replica per request. It emits a one-cycle create or kill pulse that carries the replica index, then waits for an acknowledge before it issues anything further. A comparator outside the block reports disagreement between the original and the first replica. When exactly one replica exists, such a disagreement cannot be corrected by voting, so the governor raises a sticky halt.

Top module: `redundancy_governor`

## Requirements
- R1: The activity of an accepted word is the number of set bits in its XOR with the previously accepted word (0 to 16). The previous word is all zeros after reset.
- R2: The average is the sum of the activities of the eight most recent accepted words, shifted right by three (truncating). Older words drop out of the window as new ones arrive.
- R3: No create or kill request is issued before eight words have been accepted since reset.
- R4: The target replica count is 0 for an average of 12 or more, 1 for an average of 6 to 11, and 2 for an average of 0 to 5. The governor moves `replicaCount` towards this target.
- R5: A request is a single-cycle pulse on exactly one of `createReq` or `killReq`. A create carries `reqIndex` = current count + 1, and a kill carries `reqIndex` = current count (replica 1 or 2).
- R6: At most one request is outstanding. No new pulse appears until `reqAck` is seen, and `reqAck` with nothing outstanding is ignored.
- R7: `replicaCount` rises by one on the acknowledge of a create and falls by one on the acknowledge of a kill. A move from 0 to 2 or from 2 to 0 therefore takes two separate requests.
- R8: `halt` rises on the clock edge after `cmpMismatch` is seen while `replicaCount` is 1. A mismatch at a count of 0 or 2 is ignored, and the count used is the value held before any acknowledge in the same cycle.
- R9: Once `halt` is high it stays high until reset. No further requests are issued and new words are not accepted.
- R10: After reset, `createReq`, `killReq`, `halt` and `replicaCount` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| wordValid | input | 1 | Qualifies `wordData` for one cycle |
| wordData | input | 16 | Word from the compute unit |
| reqAck | input | 1 | Outstanding create/kill has completed |
| cmpMismatch | input | 1 | Comparator reports original and replica 1 differ |
| createReq | output | 1 | One-cycle pulse: build replica `reqIndex` |
| killReq | output | 1 | One-cycle pulse: remove replica `reqIndex` |
| reqIndex | output | 2 | Replica addressed by the current pulse (1 or 2) |
| replicaCount | output | 2 | Replicas currently present (0 to 2) |
| halt | output | 1 | Sticky stop after an uncorrectable mismatch |

## Verification
The acknowledge that completes a kill of the second replica and a comparator mismatch can land in the same cycle. The halt logic must then judge the mismatch against the count of two from before the edge and not against the count of one that the acknowledge produces. The bench drives `reqAck` and `cmpMismatch` together on that edge and expects the count to become 1 with `halt` still low. A lone mismatch in the next cycle must then raise it. A second overlap, words arriving while a request waits for its acknowledge, is provoked by feeding whole windows without acking. The bench then checks that only one pulse appears and that the final count matches the arithmetic target.

// File: rtl/gov_pkg.sv
package gov_pkg;

  // Strobes from the control to the activity datapath.
  typedef struct packed {
    logic acceptWord;   // take the presented word into the window
  } ctrlStrobe_t;

  // Request handshake state of the control.
  typedef enum logic [1:0] {
    GOV_IDLE      = 2'd0,
    GOV_WAIT_UP   = 2'd1,
    GOV_WAIT_DOWN = 2'd2
  } govState_e;

endpackage

// File: rtl/gov_bitflip.sv
module gov_bitflip #(
  parameter int WORD_W = 16,
  parameter int DIST_W = 5
) (
  input  logic [WORD_W-1:0] curWord,
  input  logic [WORD_W-1:0] prevWord,
  output logic [DIST_W-1:0] flipCount
);

  logic [WORD_W-1:0] diffBits;

  always_comb begin
    diffBits  = curWord ^ prevWord;
    flipCount = '0;
    for (int i = 0; i < WORD_W; i++) begin
      flipCount = flipCount + DIST_W'(diffBits[i]);
    end
  end

endmodule

// File: rtl/gov_datapath.sv
module gov_datapath
  import gov_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int WIN_LOG2 = 3,
  parameter int DIST_W   = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [WORD_W-1:0] wordData,
  output logic [DIST_W-1:0] avgActivity,
  output logic              windowFull
);

  localparam int WIN_DEPTH = 1 << WIN_LOG2;
  localparam int SUM_W     = DIST_W + WIN_LOG2;
  localparam int FILL_W    = WIN_LOG2 + 1;
  localparam int SUM_MAX   = WORD_W * WIN_DEPTH;

  logic [WORD_W-1:0] prevWord;
  logic [DIST_W-1:0] newDist;
  logic [DIST_W-1:0] distReg [WIN_DEPTH];
  logic [SUM_W-1:0]  sumReg;
  logic [FILL_W-1:0] fillCnt;

  gov_bitflip #(
    .WORD_W (WORD_W),
    .DIST_W (DIST_W)
  ) u_bitflip (
    .curWord   (wordData),
    .prevWord  (prevWord),
    .flipCount (newDist)
  );

  // Previous word reference, cleared to zero by reset.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevWord <= '0;
    end else if (strobe.acceptWord) begin
      prevWord <= wordData;
    end
  end

  // Sliding window of per-word activity values.
  genvar g;
  generate
    for (g = 0; g < WIN_DEPTH; g++) begin : g_win
      if (g == 0) begin : g_head
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) begin
            distReg[g] <= '0;
          end else if (strobe.acceptWord) begin
            distReg[g] <= newDist;
          end
        end
      end else begin : g_tail
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) begin
            distReg[g] <= '0;
          end else if (strobe.acceptWord) begin
            distReg[g] <= distReg[g-1];
          end
        end
      end
    end
  endgenerate

  // Running sum: add the newcomer, drop the word leaving the window.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sumReg <= '0;
    end else if (strobe.acceptWord) begin
      sumReg <= sumReg + SUM_W'(newDist) - SUM_W'(distReg[WIN_DEPTH-1]);
    end
  end

  // Fill counter saturates once the window holds a full set of words.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fillCnt <= '0;
    end else if (strobe.acceptWord && (fillCnt != FILL_W'(WIN_DEPTH))) begin
      fillCnt <= fillCnt + 1'b1;
    end
  end

  assign windowFull  = (fillCnt == FILL_W'(WIN_DEPTH));
  assign avgActivity = sumReg[SUM_W-1:WIN_LOG2];

  a_r1_flip_range: assert property (@(posedge clk) disable iff (!rstN)
    newDist <= DIST_W'(WORD_W));

  a_r2_sum_bound: assert property (@(posedge clk) disable iff (!rstN)
    sumReg <= SUM_W'(SUM_MAX));

  a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.acceptWord |=> $stable(sumReg));

  a_r3_full_sticky: assert property (@(posedge clk) disable iff (!rstN)
    windowFull |=> windowFull);

endmodule

// File: rtl/gov_control.sv
module gov_control
  import gov_pkg::*;
#(
  parameter int DIST_W   = 5,
  parameter int HIGH_MIN = 12,
  parameter int LOW_MAX  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wordValid,
  input  logic [DIST_W-1:0] avgActivity,
  input  logic              windowFull,
  input  logic              reqAck,
  input  logic              cmpMismatch,
  output ctrlStrobe_t       strobe,
  output logic              createReq,
  output logic              killReq,
  output logic [1:0]        reqIndex,
  output logic [1:0]        replicaCount,
  output logic              halt
);

  localparam logic [DIST_W-1:0] HIGH_LV = DIST_W'(HIGH_MIN);
  localparam logic [DIST_W-1:0] LOW_LV  = DIST_W'(LOW_MAX);

  govState_e  state;
  logic [1:0] targetLvl;
  logic       canDecide;
  logic       stepUp;
  logic       stepDown;

  always_comb begin
    if (avgActivity >= HIGH_LV) begin
      targetLvl = 2'd0;
    end else if (avgActivity <= LOW_LV) begin
      targetLvl = 2'd2;
    end else begin
      targetLvl = 2'd1;
    end
    canDecide = windowFull && (state == GOV_IDLE) && !halt;
    stepUp    = canDecide && (targetLvl > replicaCount);
    stepDown  = canDecide && (targetLvl < replicaCount);
  end

  assign strobe.acceptWord = wordValid && !halt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state        <= GOV_IDLE;
      createReq    <= 1'b0;
      killReq      <= 1'b0;
      reqIndex     <= 2'd0;
      replicaCount <= 2'd0;
      halt         <= 1'b0;
    end else begin
      createReq <= stepUp;
      killReq   <= stepDown;
      halt      <= halt || ((replicaCount == 2'd1) && cmpMismatch);
      case (state)
        GOV_IDLE: begin
          if (stepUp) begin
            state    <= GOV_WAIT_UP;
            reqIndex <= replicaCount + 2'd1;
          end else if (stepDown) begin
            state    <= GOV_WAIT_DOWN;
            reqIndex <= replicaCount;
          end
        end
        GOV_WAIT_UP: begin
          if (reqAck) begin
            replicaCount <= replicaCount + 2'd1;
            state        <= GOV_IDLE;
          end
        end
        GOV_WAIT_DOWN: begin
          if (reqAck) begin
            replicaCount <= replicaCount - 2'd1;
            state        <= GOV_IDLE;
          end
        end
        default: state <= GOV_IDLE;
      endcase
    end
  end

  a_r3_no_early_req: assert property (@(posedge clk) disable iff (!rstN)
    (createReq || killReq) |-> windowFull);

  a_r5_one_kind: assert property (@(posedge clk) disable iff (!rstN)
    !(createReq && killReq));

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (createReq || killReq) |=> !(createReq || killReq));

  a_r5_create_index: assert property (@(posedge clk) disable iff (!rstN)
    createReq |-> (reqIndex == replicaCount + 2'd1));

  a_r5_kill_index: assert property (@(posedge clk) disable iff (!rstN)
    killReq |-> (reqIndex == replicaCount));

  a_r6_wait_quiet: assert property (@(posedge clk) disable iff (!rstN)
    ($past(state) != GOV_IDLE) |-> !(createReq || killReq));

  a_r7_count_max: assert property (@(posedge clk) disable iff (!rstN)
    replicaCount <= 2'd2);

  a_r7_count_step: assert property (@(posedge clk) disable iff (!rstN)
    (replicaCount != $past(replicaCount)) |->
      ((replicaCount == $past(replicaCount) + 2'd1) ||
       (replicaCount == $past(replicaCount) - 2'd1)));

  a_r8_halt_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(halt) |-> (($past(replicaCount) == 2'd1) && $past(cmpMismatch)));

  a_r9_halt_sticky: assert property (@(posedge clk) disable iff (!rstN)
    halt |=> halt);

  a_r9_quiet_after_halt: assert property (@(posedge clk) disable iff (!rstN)
    halt |=> !(createReq || killReq));

endmodule

// File: rtl/redundancy_governor.sv
module redundancy_governor
  import gov_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int WIN_LOG2 = 3,
  parameter int HIGH_MIN = 12,
  parameter int LOW_MAX  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wordValid,
  input  logic [WORD_W-1:0] wordData,
  input  logic              reqAck,
  input  logic              cmpMismatch,
  output logic              createReq,
  output logic              killReq,
  output logic [1:0]        reqIndex,
  output logic [1:0]        replicaCount,
  output logic              halt
);

  localparam int DIST_W = $clog2(WORD_W + 1);

  ctrlStrobe_t       strobe;
  logic [DIST_W-1:0] avgActivity;
  logic              windowFull;

  gov_datapath #(
    .WORD_W   (WORD_W),
    .WIN_LOG2 (WIN_LOG2),
    .DIST_W   (DIST_W)
  ) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .wordData    (wordData),
    .avgActivity (avgActivity),
    .windowFull  (windowFull)
  );

  gov_control #(
    .DIST_W   (DIST_W),
    .HIGH_MIN (HIGH_MIN),
    .LOW_MAX  (LOW_MAX)
  ) u_control (
    .clk          (clk),
    .rstN         (rstN),
    .wordValid    (wordValid),
    .avgActivity  (avgActivity),
    .windowFull   (windowFull),
    .reqAck       (reqAck),
    .cmpMismatch  (cmpMismatch),
    .strobe       (strobe),
    .createReq    (createReq),
    .killReq      (killReq),
    .reqIndex     (reqIndex),
    .replicaCount (replicaCount),
    .halt         (halt)
  );

endmodule

// File: tb/redundancy_governor_bench.sv
`timescale 1ns/1ps
module redundancy_governor_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wordValid = 1'b0;
  logic [15:0] wordData = '0;
  logic        reqAck = 1'b0;
  logic        cmpMismatch = 1'b0;
  logic        createReq, killReq, halt;
  logic [1:0]  reqIndex, replicaCount;

  int tests = 0;
  int fails = 0;
  int seenCnt = 0;
  int consumed = 0;
  int modelCount = 0;
  logic seenCreate = 1'b0;
  logic seenKill = 1'b0;
  logic [1:0] seenIdx = '0;
  logic prevReq = 1'b0;
  logic [15:0] lastWord = '0;
  bit finished = 0;

  always #2 clk = ~clk;

  redundancy_governor u_redundancy_governor (
    .clk          (clk),
    .rstN         (rstN),
    .wordValid    (wordValid),
    .wordData     (wordData),
    .reqAck       (reqAck),
    .cmpMismatch  (cmpMismatch),
    .createReq    (createReq),
    .killReq      (killReq),
    .reqIndex     (reqIndex),
    .replicaCount (replicaCount),
    .halt         (halt)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Request monitor: records every pulse, flags pulses longer than a cycle (R5).
  always @(negedge clk) begin
    if (rstN && (createReq || killReq)) begin
      if (prevReq) check(0, "R5", "pulse wider than one cycle", 2, 1);
      seenCnt++;
      seenCreate = createReq;
      seenKill   = killReq;
      seenIdx    = reqIndex;
    end
    prevReq = createReq || killReq;
  end

  function automatic logic [15:0] flipMask(input int d);
    if (d >= 16) return 16'hFFFF;
    return 16'((32'd1 << d) - 1);
  endfunction

  function automatic int targetFor(input int avg);
    if (avg >= 12) return 0;
    if (avg <= 5) return 2;
    return 1;
  endfunction

  task automatic doReset();
    rstN = 1'b0; wordValid = 1'b0; reqAck = 1'b0; cmpMismatch = 1'b0;
    lastWord = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    modelCount = 0;
    consumed = seenCnt;
  endtask

  task automatic putWord(input logic [15:0] w);
    @(negedge clk);
    wordValid = 1'b1;
    wordData  = w;
    lastWord  = w;
    @(posedge clk);
    #1 wordValid = 1'b0;
  endtask

  task automatic pushFlips(input int d, input int n);
    for (int i = 0; i < n; i++) putWord(lastWord ^ flipMask(d));
  endtask

  task automatic ackPulse(input bit withMismatch);
    @(negedge clk);
    reqAck = 1'b1;
    cmpMismatch = withMismatch;
    @(negedge clk);
    reqAck = 1'b0;
    cmpMismatch = 1'b0;
  endtask

  // Serve requests until the design is quiet, then compare with the target.
  task automatic settle(input int target, input string tag);
    int idle = 0;
    int guard = 0;
    while (idle < 8 && guard < 300) begin
      @(posedge clk); #1;
      guard++;
      if (seenCnt > consumed) begin
        consumed++;
        idle = 0;
        if (modelCount < target)
          check(seenCreate && !seenKill && seenIdx == 2'(modelCount + 1), "R5",
                "create index", int'(seenIdx), modelCount + 1);
        else if (modelCount > target)
          check(seenKill && !seenCreate && seenIdx == 2'(modelCount), "R5",
                "kill index", int'(seenIdx), modelCount);
        else
          check(0, "R7", "request at target level", int'(seenIdx), 0);
        ackPulse(0);
        if (seenCreate) modelCount++; else modelCount--;
        check(replicaCount == 2'(modelCount), "R7", "count after ack",
              int'(replicaCount), modelCount);
      end else begin
        idle++;
      end
    end
    check(replicaCount == 2'(target), tag, "settled replica count",
          int'(replicaCount), target);
  endtask

  initial begin
    doReset();
    // R10: reset state
    check(!createReq && !killReq, "R10", "no request after reset",
          int'(createReq) + int'(killReq), 0);
    check(replicaCount == 2'd0, "R10", "count after reset", int'(replicaCount), 0);
    check(!halt, "R10", "halt after reset", int'(halt), 0);

    // R6: acknowledge with nothing outstanding is ignored
    ackPulse(0);
    repeat (2) @(negedge clk);
    check(replicaCount == 2'd0, "R6", "stray ack ignored", int'(replicaCount), 0);

    // R8: mismatch at count 0 ignored
    @(negedge clk) cmpMismatch = 1'b1;
    @(negedge clk) cmpMismatch = 1'b0;
    check(!halt, "R8", "mismatch at count 0", int'(halt), 0);

    // R4 sweep: every constant activity 0..16, fresh start each time
    for (int d = 0; d <= 16; d++) begin
      doReset();
      pushFlips(d, 8);
      settle(targetFor(d), "R4");
    end

    // R3: seven quiet words must not trigger anything
    doReset();
    pushFlips(0, 7);
    repeat (10) @(negedge clk);
    check(seenCnt == consumed, "R3", "requests before window full",
          seenCnt - consumed, 0);
    check(replicaCount == 2'd0, "R3", "count before window full", int'(replicaCount), 0);
    pushFlips(0, 1);
    // R6: hold off the ack and confirm a single outstanding pulse
    repeat (12) @(negedge clk);
    check(seenCnt - consumed == 1, "R6", "pulses while unacked", seenCnt - consumed, 1);
    settle(2, "R7");

    // R2: sliding window drains from light to heavy activity
    pushFlips(16, 8);
    settle(0, "R2");

    // R2: truncation, sum 95 -> average 11 -> one replica
    doReset();
    pushFlips(12, 7);
    pushFlips(11, 1);
    settle(1, "R2");
    // R2: truncation, sum 47 -> average 5 -> two replicas
    doReset();
    pushFlips(6, 7);
    pushFlips(5, 1);
    settle(2, "R2");

    // R1: first word measured against zero; sum 16 -> average 2
    doReset();
    putWord(16'hFFFF);
    for (int i = 0; i < 7; i++) putWord(16'hFFFF);
    settle(2, "R1");

    // R8 / R9: halt behaviour around the single-replica state
    doReset();
    pushFlips(0, 8);
    settle(2, "R7");
    @(negedge clk) cmpMismatch = 1'b1;
    @(negedge clk) cmpMismatch = 1'b0;
    check(!halt, "R8", "mismatch at count 2", int'(halt), 0);
    pushFlips(8, 8);
    for (int i = 0; i < 40 && seenCnt == consumed; i++) @(negedge clk);
    check(seenKill && seenIdx == 2'd2 && seenCnt == consumed + 1, "R5",
          "kill of replica 2", int'(seenIdx), 2);
    consumed = seenCnt;
    ackPulse(1);   // ack and mismatch in the same cycle
    check(replicaCount == 2'd1, "R7", "count after kill ack", int'(replicaCount), 1);
    check(!halt, "R8", "mismatch judged on pre-ack count", int'(halt), 0);
    repeat (4) @(negedge clk);
    check(seenCnt == consumed, "R4", "medium holds one replica", seenCnt - consumed, 0);
    @(negedge clk) cmpMismatch = 1'b1;
    @(negedge clk) cmpMismatch = 1'b0;
    check(halt, "R8", "mismatch at count 1 halts", int'(halt), 1);
    pushFlips(16, 8);
    repeat (10) @(negedge clk);
    check(seenCnt == consumed, "R9", "no request after halt", seenCnt - consumed, 0);
    check(halt, "R9", "halt sticky", int'(halt), 1);
    check(replicaCount == 2'd1, "R9", "count frozen after halt", int'(replicaCount), 1);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL R10 watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule